// File: doc/BRIEF.md
# Latched 64-bit Match Timer

A free-running 64-bit system timer on a plain 32-bit register bus. A two-phase prescaler state machine produces one count tick every 2×(D+1) clock cycles, where D is the divider register. Six match channels each compare the low 32 bits of the count against their own match register. A hit sets a sticky status bit. Software clears that bit by writing 1 to it. Each channel drives a level interrupt that is gated by its own enable bit.

The count is read without tearing. Software first writes 1 to bit 0 of the snapshot command word, which copies all 64 bits in one cycle into two snapshot registers. It then reads the snapshot high word and after that the low word. Both counter halves are writable, so a saved count can be put back after a power state. Channel 5 is the channel intended for watchdog use. Only a readable watchdog-enable bit is held for it, and no reset is generated.

Prescaler states: `PH_FIRST` (first half-period) and `PH_SECOND` (second half-period). The transition `PH_FIRST -> PH_SECOND` is taken when the phase counter reaches D. The transition `PH_SECOND -> PH_FIRST` is taken when the phase counter reaches D, and it emits the tick. A restart (any counter-half write) forces `PH_FIRST` with the phase counter at zero, from either state.

Top module: `tmr_system_timer`

## Requirements
- R1: After reset every register reads zero (count, snapshots, match, status, enable, watchdog enable, divider) and all interrupts are low.
- R2: With divider value D (offset 0x2C), the count advances once every 2×(D+1) clock cycles. A write to either counter half restarts the prescaler, so the first advance comes 2×(D+1) cycles after that write.
- R3: The count is 64 bits wide and carries from the low word (offset 0x00) into the high word (offset 0x04). Each half is writable, and a write to it takes priority over the increment in that cycle.
- R4: Writing a word with bit 0 set to offset 0x30 copies the count as it stood before that edge into the snapshot words (low at 0x34, high at 0x38). The snapshot then holds until the next such write. A write with bit 0 clear has no effect.
- R5: Status bit n (offset 0x20) is set on a tick on which the count low word equals match register n (offset 0x08 + 4n). Only equality triggers, so a match value already passed does not fire.
- R6: Writing 1 to status bit n clears it, and writing 0 leaves it unchanged. If a hit happens in the same cycle, the set wins.
- R7: irq[n] is high exactly when status bit n and enable bit n (offset 0x24, bit n) are both 1.
- R8: The match, enable (bits 5:0), watchdog enable (offset 0x28, bit 0), divider (low DIV_W bits) and snapshot registers are read/write. Offset 0x30, unmapped offsets and accesses with address bits 1:0 nonzero read zero, and such writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 6 | Level interrupt per match channel |

## Verification
Register writes take effect at the clock edge that samples them, and read data is combinational, so the bench drives on the falling edge and reads shortly after it. The count advances 2×(D+1) edges after a counter write. A snapshot taken k edges after that write therefore holds floor((k−1)/(2×(D+1))), and the bench places its snapshot writes at exact edge counts. A status bit becomes visible right after the tick edge that leaves the matched value, which is edge 2×(D+1)×(M+1) after the counter was written to zero. The bench reads status one edge before that point and again on it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_CH = 6;
    localparam int WORD_W = 32;

    // word indices (byte offset / 4)
    localparam int W_CNT_LO  = 0;
    localparam int W_CNT_HI  = 1;
    localparam int W_MATCH0  = 2;
    localparam int W_STATUS  = 8;
    localparam int W_INT_EN  = 9;
    localparam int W_WDOG    = 10;
    localparam int W_DIV     = 11;
    localparam int W_LATCH   = 12;
    localparam int W_SNAP_LO = 13;
    localparam int W_SNAP_HI = 14;

    typedef enum logic [0:0] {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    phase_e            ph_q, ph_d;
    logic [DIV_W-1:0]  pc_q, pc_d;
    logic              half_done;

    assign half_done = (pc_q >= div);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_FIRST;
            pc_q <= '0;
        end else begin
            ph_q <= ph_d;
            pc_q <= pc_d;
        end
    end

    // next state
    always_comb begin
        ph_d = ph_q;
        pc_d = pc_q + DIV_W'(1);
        if (restart) begin
            ph_d = PH_FIRST;
            pc_d = '0;
        end else begin
            unique case (ph_q)
                PH_FIRST: begin
                    if (half_done) begin
                        ph_d = PH_SECOND;
                        pc_d = '0;
                    end
                end
                PH_SECOND: begin
                    if (half_done) begin
                        ph_d = PH_FIRST;
                        pc_d = '0;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tick = !restart && (ph_q == PH_SECOND) && half_done;
    end
endmodule

// File: rtl/tmr_counter64.sv
module tmr_counter64
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                latch_go,
    input  logic                snap_wr_lo,
    input  logic                snap_wr_hi,
    output logic [2*WORD_W-1:0] cnt,
    output logic [2*WORD_W-1:0] snap
);
    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[WORD_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (latch_go) begin
            snap_q <= cnt_q;
        end else begin
            if (snap_wr_lo) snap_q[WORD_W-1:0]     <= wdata;
            if (snap_wr_hi) snap_q[CNT_W-1:WORD_W] <= wdata;
        end
    end

    assign cnt  = cnt_q;
    assign snap = snap_q;
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
    import tmr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic [WORD_W-1:0]              cnt_lo,
    input  logic [NUM_CH-1:0]              match_wr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [NUM_CH-1:0]              clr,
    output logic [NUM_CH-1:0][WORD_W-1:0]  match_q,
    output logic [NUM_CH-1:0]              status_q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WORD_W-1:0] m_r;
        logic              s_r;
        logic              hit;

        assign hit = tick && (cnt_lo == m_r);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_r <= '0;
                s_r <= 1'b0;
            end else begin
                if (match_wr[c]) m_r <= wdata;
                if (hit)         s_r <= 1'b1;   // set beats clear
                else if (clr[c]) s_r <= 1'b0;
            end
        end

        assign match_q[c]  = m_r;
        assign status_q[c] = s_r;
    end
endmodule

// File: rtl/tmr_system_timer.sv
module tmr_system_timer
    import tmr_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [5:0]        irq
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]             widx;
    logic                          aligned;
    logic                          wr_cnt_lo, wr_cnt_hi, wr_status, wr_en;
    logic                          wr_wdog, wr_div, wr_latch, wr_snap_lo, wr_snap_hi;
    logic [NUM_CH-1:0]             match_wr;
    logic [NUM_CH-1:0]             clr;
    logic                          tick;
    logic [2*WORD_W-1:0]           cnt_q;
    logic [2*WORD_W-1:0]           snap_q;
    logic [NUM_CH-1:0][WORD_W-1:0] match_q;
    logic [NUM_CH-1:0]             status_q;
    logic [NUM_CH-1:0]             en_q;
    logic                          wdog_q;
    logic [DIV_W-1:0]              div_q;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    function automatic logic hit_w(input logic [WIDX_W-1:0] w, input int idx);
        return (int'(w) == idx);
    endfunction

    assign wr_cnt_lo  = bus_we && aligned && hit_w(widx, W_CNT_LO);
    assign wr_cnt_hi  = bus_we && aligned && hit_w(widx, W_CNT_HI);
    assign wr_status  = bus_we && aligned && hit_w(widx, W_STATUS);
    assign wr_en      = bus_we && aligned && hit_w(widx, W_INT_EN);
    assign wr_wdog    = bus_we && aligned && hit_w(widx, W_WDOG);
    assign wr_div     = bus_we && aligned && hit_w(widx, W_DIV);
    assign wr_latch   = bus_we && aligned && hit_w(widx, W_LATCH) && bus_wdata[0];
    assign wr_snap_lo = bus_we && aligned && hit_w(widx, W_SNAP_LO);
    assign wr_snap_hi = bus_we && aligned && hit_w(widx, W_SNAP_HI);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mdec
        assign match_wr[c] = bus_we && aligned && hit_w(widx, W_MATCH0 + c);
    end

    assign clr = {NUM_CH{wr_status}} & bus_wdata[NUM_CH-1:0];

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            wdog_q <= 1'b0;
            div_q  <= '0;
        end else begin
            if (wr_en)   en_q   <= bus_wdata[NUM_CH-1:0];
            if (wr_wdog) wdog_q <= bus_wdata[0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div_q),
        .restart (wr_cnt_lo || wr_cnt_hi),
        .tick    (tick)
    );

    tmr_counter64 u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_lo      (wr_cnt_lo),
        .wr_hi      (wr_cnt_hi),
        .wdata      (bus_wdata),
        .latch_go   (wr_latch),
        .snap_wr_lo (wr_snap_lo),
        .snap_wr_hi (wr_snap_hi),
        .cnt        (cnt_q),
        .snap       (snap_q)
    );

    tmr_match_bank u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_lo   (cnt_q[WORD_W-1:0]),
        .match_wr (match_wr),
        .wdata    (bus_wdata),
        .clr      (clr),
        .match_q  (match_q),
        .status_q (status_q)
    );

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (int'(widx))
                W_CNT_LO:  bus_rdata = cnt_q[WORD_W-1:0];
                W_CNT_HI:  bus_rdata = cnt_q[2*WORD_W-1:WORD_W];
                W_STATUS:  bus_rdata = 32'(status_q);
                W_INT_EN:  bus_rdata = 32'(en_q);
                W_WDOG:    bus_rdata = 32'(wdog_q);
                W_DIV:     bus_rdata = 32'(div_q);
                W_SNAP_LO: bus_rdata = snap_q[WORD_W-1:0];
                W_SNAP_HI: bus_rdata = snap_q[2*WORD_W-1:WORD_W];
                default: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (int'(widx) == W_MATCH0 + c) bus_rdata = match_q[c];
                    end
                end
            endcase
        end
    end

    assign irq = status_q & en_q;
endmodule

// File: rtl/tmr_system_timer_chk.sv
module tmr_system_timer_chk
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                tick,
    input logic [2*WORD_W-1:0] cnt,
    input logic [2*WORD_W-1:0] snap,
    input logic [NUM_CH-1:0]   status
);
    logic [ADDR_W-3:0] w;
    logic              al;
    assign w  = bus_addr[ADDR_W-1:2];
    assign al = (bus_addr[1:0] == 2'b00);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && al && (int'(w) == W_CNT_LO || int'(w) == W_CNT_HI))
        |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && al && int'(w) == W_LATCH && bus_wdata[0]) |=> (snap == $past(cnt)));

    // R5
    status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~$past(status))) |-> $past(tick));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && al && int'(w) == W_STATUS && !tick)
        |=> ((status & $past(bus_wdata[NUM_CH-1:0])) == '0));

    // R8
    latch_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(w) == W_LATCH) |-> (bus_rdata == 32'd0));
endmodule

bind tmr_system_timer tmr_system_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .cnt       (cnt_q),
    .snap      (snap_q),
    .status    (status_q)
);

// File: tb/tb_tmr_system_timer.sv
`timescale 1ns/100ps
module tb_tmr_system_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_system_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_M0 = 8'h08, A_M1 = 8'h0C,
        A_M2 = 8'h10, A_M3 = 8'h14, A_M4 = 8'h18, A_M5 = 8'h1C, A_ST = 8'h20,
        A_EN = 8'h24, A_WD = 8'h28, A_DIV = 8'h2C, A_LAT = 8'h30, A_SLO = 8'h34,
        A_SHI = 8'h38;

    // {write, addr, data, expected}; read rows compare rdata with expected (R8)
    localparam int NV = 20;
    localparam logic [72:0] VEC [0:NV-1] = '{
        {1'b1, 8'h08, 32'h1111_1111, 32'h0},
        {1'b0, 8'h08, 32'h0,         32'h1111_1111},
        {1'b1, 8'h1C, 32'hA5A5_5A5A, 32'h0},
        {1'b0, 8'h1C, 32'h0,         32'hA5A5_5A5A},
        {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h24, 32'h0,         32'h0000_003F},
        {1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h28, 32'h0,         32'h0000_0001},
        {1'b1, 8'h2C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h2C, 32'h0,         32'h0000_FFFF},
        {1'b0, 8'h30, 32'h0,         32'h0},
        {1'b1, 8'h34, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 8'h34, 32'h0,         32'hDEAD_BEEF},
        {1'b1, 8'h38, 32'h1234_5678, 32'h0},
        {1'b0, 8'h38, 32'h0,         32'h1234_5678},
        {1'b1, 8'h2D, 32'h0000_0007, 32'h0},
        {1'b0, 8'h2C, 32'h0,         32'h0000_FFFF},
        {1'b0, 8'h3C, 32'h0,         32'h0},
        {1'b1, 8'h2C, 32'h0,         32'h0},
        {1'b1, 8'h24, 32'h0,         32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        waitn(3);
        rst_n = 1'b1;
        // R1: before the first edge after reset release
        rd_chk("R1 cnt lo", A_LO, 32'h0);
        rd_chk("R1 status", A_ST, 32'h0);
        rd_chk("R1 div", A_DIV, 32'h0);
        rd_chk("R1 snap hi", A_SHI, 32'h0);
        rd_chk("R1 match5", A_M5, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        @(negedge clk);

        // R8 table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else rd_chk("R8 register", VEC[i][71:64], VEC[i][31:0]);
        end

        // R2: D=0, 20 edges -> 10
        wr(A_DIV, 0); wr(A_HI, 0); wr(A_LO, 0);
        waitn(20);
        wr(A_LAT, 1);
        rd_chk("R4 snap hi", A_SHI, 32'h0);
        rd_chk("R2 D=0 rate", A_SLO, 32'd10);

        // R4: snapshot holds, bit0 clear ignored
        waitn(30);
        wr(A_LAT, 32'hFFFF_FFFE);
        rd_chk("R4 hold", A_SLO, 32'd10);

        // R2: D=3, 37 edges -> 4
        wr(A_DIV, 3); wr(A_HI, 0); wr(A_LO, 0);
        waitn(37);
        wr(A_LAT, 1);
        rd_chk("R2 D=3 rate", A_SLO, 32'd4);

        // R3: carry into high word
        wr(A_DIV, 0); wr(A_HI, 5); wr(A_LO, 32'hFFFF_FFFF);
        waitn(2);
        wr(A_LAT, 1);
        rd_chk("R3 carry hi", A_SHI, 32'd6);
        rd_chk("R3 carry lo", A_SLO, 32'd0);
        rd_chk("R3 live hi", A_HI, 32'd6);

        // R5/R7: channels 0,1,5 match 10; enable 0 and 5
        wr(A_M0, 10); wr(A_M1, 10); wr(A_M5, 10);
        wr(A_M2, 32'hFFFF_FFF0); wr(A_M3, 32'hFFFF_FFF0); wr(A_M4, 32'hFFFF_FFF0);
        wr(A_EN, 32'h21);
        wr(A_HI, 0); wr(A_LO, 0);
        wr(A_ST, 32'h3F);
        waitn(20);
        rd_chk("R5 before match", A_ST, 32'h0);
        chk("R7 irq before", 32'(irq), 32'h0);
        waitn(1);
        rd_chk("R5 on match", A_ST, 32'h23);
        chk("R7 irq gated", 32'(irq), 32'h21);

        // R6
        wr(A_ST, 32'h1);
        rd_chk("R6 w1c", A_ST, 32'h22);
        chk("R6 irq after clear", 32'(irq), 32'h20);
        wr(A_ST, 32'h0);
        rd_chk("R6 zero write", A_ST, 32'h22);

        // R5: past value does not fire
        wr(A_M2, 3);
        waitn(40);
        rd_chk("R5 past value", A_ST, 32'h22);

        // R7
        wr(A_EN, 32'h0);
        chk("R7 all disabled", 32'(irq), 32'h0);
        wr(A_EN, 32'h2);
        chk("R7 channel1", 32'(irq), 32'h02);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule